// File: doc/BRIEF.md
# Load-Balancing Request Distributor

This block sits on the ingress side of a switch fabric made of several parallel switch elements. Cells that arrive for a destination port are announced to it by an arrival strobe. The block keeps a count of outstanding cells for each destination. It also keeps a local copy of how many requests each switch element still holds for each destination. Switch elements report nothing back about their load, so this local copy is the only load information the block has.

In each decision slot the block does three things. It selects a destination with outstanding cells in rotating order. It looks up the switch elements that are enabled and not full for that destination and finds the smallest tracked queue length among them. It picks one of the elements at that minimum using a pseudo-random value. The chosen request (destination, switch element) is placed in an output register and offered on a valid/ready handshake.

A grant returned from switch element p for destination j lowers the matching tracked count. A count that has reached the remote queue depth blocks further requests to that element, which gives backpressure without loss. A per-element off mask steers all traffic around failed elements.

Top module: `lb_req_distributor`

## Requirements
- R1: After reset no request is offered (`req_vld` = 0), and it stays low while no arrival has been seen.
- R2: Destinations with outstanding cells are served in rotating order. After destination j is served or skipped, the search restarts at j+1 and wraps around, so three busy destinations with two cells each come out as two identical rounds.
- R3: The offered switch element holds, for the offered destination, the smallest tracked count among the elements that are enabled and below `DEPTH`.
- R4: When several eligible elements share that minimum, the choice among them comes from a free-running 16-bit LFSR, and every tied element is chosen over repeated trials.
- R5: The tracked count for (element p, destination j) rises by one when a request for j is committed to p. It falls by one when `grant_vld[p]` is high with `grant_dst[p]` = j. When both happen in the same cycle, the count is unchanged.
- R6: No request for destination j is sent to an element whose tracked count for j equals `DEPTH`. A grant from that element makes it eligible again.
- R7: An element with `se_off[p]` = 1 is never chosen.
- R8: If the selected destination has no eligible element, nothing is issued for it in that slot and the rotation moves on, so other destinations are still served.
- R9: Each arrival (`arr_vld` with `arr_dst`) produces exactly one request, including when an arrival and an issue for the same destination fall in the same cycle.
- R10: While `req_vld` is high and `req_rdy` is low, `req_vld`, `req_dst` and `req_se` hold steady. A new request is committed in any cycle where the output register is empty or being accepted, so the block sustains one request per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| arr_vld | input | 1 | Cell arrival strobe |
| arr_dst | input | DW | Destination of the arriving cell |
| se_off | input | NUM_SE | Per-element disable mask |
| grant_vld | input | NUM_SE | Grant returned by each element |
| grant_dst | input | NUM_SE*DW | Destination of each returned grant |
| req_vld | output | 1 | Request offered |
| req_rdy | input | 1 | Request accepted downstream |
| req_dst | output | DW | Destination of the offered request |
| req_se | output | SW | Chosen switch element |

## Verification
The bench builds the block with four destinations, four switch elements and a remote depth of three. With these values a single destination can fill every element within twelve arrivals, so the all-full skip, the resume after one grant and the per-element cap are all reached in a few dozen cycles. Two enabled elements left tied on an otherwise idle destination make the random tie-break observable across a short run of trials. Each issued request is checked against a bench-side mirror of the tracked counts.

// File: rtl/lbd_pkg.sv
package lbd_pkg;

    localparam int          LFSR_W    = 16;
    localparam logic [15:0] LFSR_SEED = 16'hACE1;
    localparam int          RND_W     = 8;

    typedef enum logic [1:0] {
        DEC_IDLE,
        DEC_SKIP,
        DEC_ISSUE
    } dec_e;

    function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] s);
        return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    endfunction

    function automatic int idx_w(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/lbd_lfsr.sv
module lbd_lfsr
    import lbd_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    output logic [RND_W-1:0] rnd
);

    logic [LFSR_W-1:0] state;

    always_ff @(posedge clk) begin
        if (rst) state <= LFSR_SEED;
        else     state <= lfsr_step(state);
    end

    assign rnd = state[15:8] ^ state[7:0];

    // R4
    lfsr_alive_chk: assert property (@(posedge clk) disable iff (rst)
        state != '0);

endmodule

// File: rtl/lbd_rr_arb.sv
module lbd_rr_arb #(
    parameter int N  = 64,
    parameter int IW = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [N-1:0]  req,
    input  logic          adv,
    output logic          gnt_vld,
    output logic [IW-1:0] gnt_idx
);

    logic [IW-1:0] ptr;
    int            t;
    int            nx;

    always_comb begin
        gnt_vld = 1'b0;
        gnt_idx = '0;
        t       = 0;
        for (int k = N - 1; k >= 0; k--) begin
            t = int'(ptr) + k;
            if (t >= N) t = t - N;
            if (req[t]) begin
                gnt_vld = 1'b1;
                gnt_idx = IW'(t);
            end
        end
    end

    always_comb begin
        nx = int'(gnt_idx) + 1;
        if (nx >= N) nx = 0;
    end

    always_ff @(posedge clk) begin
        if (rst)                 ptr <= '0;
        else if (adv && gnt_vld) ptr <= IW'(nx);
    end

    // R2
    arb_pick_chk: assert property (@(posedge clk) disable iff (rst)
        gnt_vld |-> req[gnt_idx]);

    // R2
    arb_any_chk: assert property (@(posedge clk) disable iff (rst)
        (|req) |-> gnt_vld);

endmodule

// File: rtl/lbd_min_pick.sv
module lbd_min_pick
    import lbd_pkg::*;
#(
    parameter int NUM_SE = 8,
    parameter int CW     = 4,
    parameter int SW     = 3,
    parameter int DEPTH  = 15
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [NUM_SE-1:0][CW-1:0]   len,
    input  logic [NUM_SE-1:0]           off,
    input  logic [RND_W-1:0]            rnd,
    output logic                        sel_vld,
    output logic [SW-1:0]               sel
);

    localparam int PW = RND_W + SW + 1;

    logic [NUM_SE-1:0] elig;
    logic [NUM_SE-1:0] cand;
    logic [CW-1:0]     minv;
    logic [SW:0]       ntied;
    logic [SW:0]       target;
    logic [SW:0]       seen;
    logic [PW-1:0]     prod;

    always_comb begin
        minv = CW'(DEPTH);
        for (int p = 0; p < NUM_SE; p++) begin
            elig[p] = !off[p] && (len[p] < CW'(DEPTH));
            if (elig[p] && len[p] < minv) minv = len[p];
        end
        ntied = '0;
        for (int p = 0; p < NUM_SE; p++) begin
            cand[p] = elig[p] && (len[p] == minv);
            ntied   = ntied + (SW+1)'(cand[p]);
        end
    end

    // scale the random value onto [0, ntied) and take that tied candidate
    always_comb begin
        prod   = PW'(rnd) * PW'(ntied);
        target = prod[RND_W +: SW+1];
        seen   = '0;
        sel    = '0;
        for (int p = 0; p < NUM_SE; p++) begin
            if (cand[p] && seen == target) sel = SW'(p);
            seen = seen + (SW+1)'(cand[p]);
        end
        sel_vld = |cand;
    end

    // R3
    pick_in_set_chk: assert property (@(posedge clk) disable iff (rst)
        sel_vld |-> (elig[sel] && len[sel] == minv));

    for (genvar g = 0; g < NUM_SE; g++) begin : g_min
        // R3
        pick_min_chk: assert property (@(posedge clk) disable iff (rst)
            (sel_vld && elig[g]) |-> (len[sel] <= len[g]));
    end

endmodule

// File: rtl/lb_req_distributor.sv
module lb_req_distributor
    import lbd_pkg::*;
#(
    parameter int NUM_DST = 64,
    parameter int NUM_SE  = 8,
    parameter int DEPTH   = 15,
    parameter int PEND_W  = 8,
    localparam int DW     = idx_w(NUM_DST),
    localparam int SW     = idx_w(NUM_SE),
    localparam int CW     = $clog2(DEPTH + 1)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      arr_vld,
    input  logic [DW-1:0]             arr_dst,
    input  logic [NUM_SE-1:0]         se_off,
    input  logic [NUM_SE-1:0]         grant_vld,
    input  logic [NUM_SE-1:0][DW-1:0] grant_dst,
    output logic                      req_vld,
    input  logic                      req_rdy,
    output logic [DW-1:0]             req_dst,
    output logic [SW-1:0]             req_se
);

    typedef struct packed {
        logic [DW-1:0] dst;
        logic [SW-1:0] se;
    } req_t;

    logic [NUM_DST-1:0][PEND_W-1:0]       pend;
    logic [NUM_DST-1:0][NUM_SE-1:0][CW-1:0] track;
    logic [NUM_DST-1:0]                   pend_nz, pend_up, pend_dn;
    logic [NUM_DST-1:0][NUM_SE-1:0]       trk_up, trk_dn;

    logic          vld_q;
    req_t          req_q;
    logic          arb_vld;
    logic [DW-1:0] arb_idx;
    logic          pick_vld;
    logic [SW-1:0] pick_se;
    logic [RND_W-1:0] rnd;
    logic          can_take;
    logic          load;
    dec_e          dec;

    always_comb begin
        for (int j = 0; j < NUM_DST; j++) pend_nz[j] = (pend[j] != '0);
    end

    lbd_lfsr i_lfsr (
        .clk (clk),
        .rst (rst),
        .rnd (rnd)
    );

    lbd_rr_arb #(.N(NUM_DST), .IW(DW)) i_arb (
        .clk     (clk),
        .rst     (rst),
        .req     (pend_nz),
        .adv     (dec != DEC_IDLE),
        .gnt_vld (arb_vld),
        .gnt_idx (arb_idx)
    );

    lbd_min_pick #(.NUM_SE(NUM_SE), .CW(CW), .SW(SW), .DEPTH(DEPTH)) i_pick (
        .clk     (clk),
        .rst     (rst),
        .len     (track[arb_idx]),
        .off     (se_off),
        .rnd     (rnd),
        .sel_vld (pick_vld),
        .sel     (pick_se)
    );

    always_comb begin
        can_take = !vld_q || req_rdy;
        if (!arb_vld || !can_take) dec = DEC_IDLE;
        else if (pick_vld)         dec = DEC_ISSUE;
        else                       dec = DEC_SKIP;
        load = (dec == DEC_ISSUE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= 1'b0;
            req_q <= '0;
        end else if (load) begin
            vld_q     <= 1'b1;
            req_q.dst <= arb_idx;
            req_q.se  <= pick_se;
        end else if (req_rdy) begin
            vld_q <= 1'b0;
        end
    end

    assign req_vld = vld_q;
    assign req_dst = req_q.dst;
    assign req_se  = req_q.se;

    always_comb begin
        for (int j = 0; j < NUM_DST; j++) begin
            pend_up[j] = arr_vld && (arr_dst == DW'(j));
            pend_dn[j] = load && (arb_idx == DW'(j));
            for (int p = 0; p < NUM_SE; p++) begin
                trk_up[j][p] = pend_dn[j] && (pick_se == SW'(p));
                trk_dn[j][p] = grant_vld[p] && (grant_dst[p] == DW'(j));
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend  <= '0;
            track <= '0;
        end else begin
            for (int j = 0; j < NUM_DST; j++) begin
                case ({pend_up[j], pend_dn[j]})
                    2'b10:   pend[j] <= pend[j] + 1'b1;
                    2'b01:   pend[j] <= pend[j] - 1'b1;
                    default: pend[j] <= pend[j];
                endcase
                for (int p = 0; p < NUM_SE; p++) begin
                    case ({trk_up[j][p], trk_dn[j][p]})
                        2'b10:   track[j][p] <= track[j][p] + 1'b1;
                        2'b01:   track[j][p] <= track[j][p] - 1'b1;
                        default: track[j][p] <= track[j][p];
                    endcase
                end
            end
        end
    end

    // R10
    out_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (req_vld && !req_rdy) |=> (req_vld && $stable(req_dst) && $stable(req_se)));

    // R6
    no_overfill_chk: assert property (@(posedge clk) disable iff (rst)
        load |-> (track[arb_idx][pick_se] < CW'(DEPTH)));

    // R7
    skip_off_chk: assert property (@(posedge clk) disable iff (rst)
        load |-> !se_off[pick_se]);

    // R9
    pend_live_chk: assert property (@(posedge clk) disable iff (rst)
        load |-> (pend[arb_idx] != '0));

    // R8
    skip_cause_chk: assert property (@(posedge clk) disable iff (rst)
        (dec == DEC_SKIP) |-> !pick_vld);

    for (genvar g = 0; g < NUM_SE; g++) begin : g_gnt
        // R5
        grant_legal_chk: assert property (@(posedge clk) disable iff (rst)
            grant_vld[g] |-> (track[grant_dst[g]][g] != '0));
    end

endmodule

// File: tb/test_lb_req_distributor.sv
module test_lb_req_distributor;

    localparam int ND = 4;
    localparam int NS = 4;
    localparam int DP = 3;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic                arr_vld = 1'b0;
    logic [1:0]          arr_dst = '0;
    logic [NS-1:0]       se_off = '0;
    logic [NS-1:0]       grant_vld = '0;
    logic [NS-1:0][1:0]  grant_dst = '0;
    logic                req_vld;
    logic                req_rdy = 1'b0;
    logic [1:0]          req_dst;
    logic [1:0]          req_se;

    int n_chk = 0;
    int n_bad = 0;
    int mtrk [NS][ND];
    int seq_d [64];
    int seq_s [64];
    int n_seq;

    always #4 clk = ~clk;

    lb_req_distributor #(.NUM_DST(ND), .NUM_SE(NS), .DEPTH(DP), .PEND_W(6)) i_lb_req_distributor (
        .clk       (clk),
        .rst       (rst),
        .arr_vld   (arr_vld),
        .arr_dst   (arr_dst),
        .se_off    (se_off),
        .grant_vld (grant_vld),
        .grant_dst (grant_dst),
        .req_vld   (req_vld),
        .req_rdy   (req_rdy),
        .req_dst   (req_dst),
        .req_se    (req_se)
    );

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic arrive(input int d);
        arr_vld = 1'b1;
        arr_dst = 2'(d);
        step();
        arr_vld = 1'b0;
    endtask

    task automatic grant(input int p, input int d);
        grant_vld[p] = 1'b1;
        grant_dst[p] = 2'(d);
        step();
        grant_vld[p] = 1'b0;
        mtrk[p][d]--;
    endtask

    task automatic grant_all();
        for (int p = 0; p < NS; p++)
            for (int d = 0; d < ND; d++)
                while (mtrk[p][d] > 0) grant(p, d);
    endtask

    // validate the offered request against the mirrored counts (R3, R6, R7)
    task automatic take(output int d, output int s);
        int mn;
        d = int'(req_dst);
        s = int'(req_se);
        chk(se_off[s] == 1'b0, "R7", int'(se_off[s]), 0);
        chk(mtrk[s][d] < DP, "R6", mtrk[s][d], DP - 1);
        mn = 99;
        for (int p = 0; p < NS; p++)
            if (!se_off[p] && mtrk[p][d] < DP && mtrk[p][d] < mn) mn = mtrk[p][d];
        chk(mtrk[s][d] == mn, "R3", mtrk[s][d], mn);
        mtrk[s][d]++;
    endtask

    task automatic drain(input int cycles);
        n_seq = 0;
        req_rdy = 1'b1;
        for (int c = 0; c < cycles; c++) begin
            if (req_vld) begin
                int d, s;
                take(d, s);
                seq_d[n_seq] = d;
                seq_s[n_seq] = s;
                n_seq++;
            end
            step();
        end
        req_rdy = 1'b0;
    endtask

    task automatic t_reset();
        for (int k = 0; k < 4; k++) chk(req_vld == 1'b0, "R1", int'(req_vld), 0);
        repeat (5) step();
        chk(req_vld == 1'b0, "R1", int'(req_vld), 0);
    endtask

    task automatic t_round_robin();
        for (int d = 0; d < 3; d++) begin
            arrive(d);
            arrive(d);
        end
        drain(20);
        chk(n_seq == 6, "R9", n_seq, 6);
        chk(seq_d[0] != seq_d[1] && seq_d[1] != seq_d[2] && seq_d[0] != seq_d[2],
            "R2", seq_d[1], seq_d[0] + 1);
        for (int k = 0; k < 3; k++) chk(seq_d[k+3] == seq_d[k], "R2", seq_d[k+3], seq_d[k]);
        grant_all();
    endtask

    task automatic t_spread_and_full();
        bit seen [NS];
        for (int p = 0; p < NS; p++) seen[p] = 1'b0;
        for (int k = 0; k < 4; k++) arrive(3);
        drain(12);
        chk(n_seq == 4, "R3", n_seq, 4);
        for (int k = 0; k < n_seq; k++) begin
            chk(!seen[seq_s[k]], "R3", seq_s[k], -1);
            seen[seq_s[k]] = 1'b1;
        end
        for (int k = 0; k < 8; k++) arrive(3);
        drain(20);
        chk(n_seq == 8, "R6", n_seq, 8);
        // every element full for destination 3: it must be skipped, 1 still served
        arrive(3);
        arrive(1);
        drain(20);
        chk(n_seq == 1, "R8", n_seq, 1);
        chk(seq_d[0] == 1, "R8", seq_d[0], 1);
        drain(10);
        chk(n_seq == 0, "R6", n_seq, 0);
        grant(2, 3);
        drain(10);
        chk(n_seq == 1, "R5", n_seq, 1);
        chk(seq_d[0] == 3 && seq_s[0] == 2, "R6", seq_s[0], 2);
        grant_all();
    endtask

    task automatic t_mask();
        se_off = 4'b0101;
        for (int k = 0; k < 4; k++) arrive(2);
        drain(12);
        chk(n_seq == 4, "R7", n_seq, 4);
        for (int k = 0; k < n_seq; k++) chk(seq_s[k] == 1 || seq_s[k] == 3, "R7", seq_s[k], 1);
        grant_all();
        se_off = '0;
    endtask

    task automatic t_tie();
        int hits [NS];
        for (int p = 0; p < NS; p++) hits[p] = 0;
        se_off = 4'b0011;
        for (int k = 0; k < 24; k++) begin
            arrive(1);
            drain(3);
            chk(n_seq == 1, "R4", n_seq, 1);
            hits[seq_s[0]]++;
            grant(seq_s[0], 1);
        end
        chk(hits[2] > 0, "R4", hits[2], 1);
        chk(hits[3] > 0, "R4", hits[3], 1);
        chk(hits[2] + hits[3] == 24, "R7", hits[2] + hits[3], 24);
        se_off = '0;
    endtask

    task automatic t_handshake();
        int d0, s0, d, s;
        arrive(0);
        step();
        chk(req_vld == 1'b1, "R10", int'(req_vld), 1);
        d0 = int'(req_dst);
        s0 = int'(req_se);
        for (int k = 0; k < 5; k++) begin
            step();
            chk(req_vld == 1'b1 && int'(req_dst) == d0 && int'(req_se) == s0, "R10", int'(req_se), s0);
        end
        drain(3);
        chk(n_seq == 1, "R10", n_seq, 1);
        grant_all();
        // back-to-back issue, includes arrival and issue for dst 1 in one cycle
        arrive(1);
        arrive(1);
        arrive(1);
        step();
        req_rdy = 1'b1;
        for (int k = 0; k < 3; k++) begin
            chk(req_vld == 1'b1, "R10", int'(req_vld), 1);
            if (req_vld) take(d, s);
            step();
        end
        req_rdy = 1'b0;
        chk(req_vld == 1'b0, "R9", int'(req_vld), 0);
        grant_all();
    endtask

    task automatic t_stream();
        int got = 0;
        int d, s;
        req_rdy = 1'b1;
        for (int k = 0; k < 10; k++) begin
            arr_vld = 1'b1;
            arr_dst = 2'd0;
            if (req_vld) begin
                take(d, s);
                got++;
            end
            step();
        end
        arr_vld = 1'b0;
        for (int k = 0; k < 12; k++) begin
            if (req_vld) begin
                take(d, s);
                got++;
            end
            step();
        end
        req_rdy = 1'b0;
        chk(got == 10, "R9", got, 10);
        grant_all();
        drain(8);
        chk(n_seq == 0, "R5", n_seq, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        summary();
    end

    initial begin
        for (int p = 0; p < NS; p++)
            for (int d = 0; d < ND; d++) mtrk[p][d] = 0;
        rst = 1'b1;
        repeat (3) step();
        rst = 1'b0;
        t_reset();
        t_round_robin();
        t_spread_and_full();
        t_mask();
        t_tie();
        t_handshake();
        t_stream();
        summary();
    end

endmodule